// File: doc/BRIEF.md
# Two-Channel Configurable External Interrupt Detector

This block turns asynchronous pin activity into interrupt requests. It has two independent channels, and each channel owns a group of sixteen input pins. Software writes one 32-bit control word, and each channel reads its own byte of that word. From the byte a channel takes the pin to watch, the active polarity, the detection style and an enable.

Each selected pin passes through a synchronizer. The detector then does one of three things:

- In level style it reports whether the pin sits at the active level.
- In single-edge style it latches a pending request on the edge whose direction the polarity names.
- In both-edges style it latches on any transition and ignores the polarity.

A latched request stays up until the per-channel clear input removes it. A change of pin selection never produces a false edge.

Top module: `ext_irq_detect`

## Requirements
- R1: Reset (synchronous, active high) sets the control word to all zeros, so every channel is disabled and every request output is low.
- R2: Channel c decodes byte c of the control word: bits [3:0] are the pin select, bit [4] is the polarity, bits [6:5] are the style (0 level, 1 single edge, 2 both edges, 3 reserved) and bit [7] is the enable. Bits above the last channel byte have no effect.
- R3: In level style, the request equals the synchronized pin compared with the polarity: high when the pin is 1 and the polarity is 1, or when the pin is 0 and the polarity is 0. A pin change shows on the request after the second rising clock edge.
- R4: In single-edge style, polarity 1 latches on a rising edge and polarity 0 latches on a falling edge. An edge in the other direction latches nothing. The request rises after the third rising clock edge following the pin change.
- R5: In both-edges style, a rise and a fall both latch a request, whatever the polarity bit holds.
- R6: A latched request holds until its clear input is sampled high at a clock edge. If a new edge is detected at that same edge, the request stays set.
- R7: A channel whose enable is 0, or whose style is 3, drives its request low and drops any latched request.
- R8: A select value N routes pin N of that channel's group to the detector. The other fifteen pins of the group have no effect.
- R9: Rewriting a channel's pin select never latches a request, even when the old pin and the new pin sit at different levels.
- R10: The channels are independent. The clear input and the configuration of one channel leave the other channel's request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word value written on a strobe |
| pins_in | input | 32 | Pin groups; channel c uses bits [16c+15:16c] |
| irq_clr | input | 2 | Per-channel clear of a latched request |
| irq_req | output | 2 | Per-channel interrupt request |

## Verification
The configuration acts on the first edge that samples a write, and a level-style result becomes visible two edges after a pin change. An edge-style request appears three edges after the pin change, because of two synchronizer stages plus the pending register. A clear acts at the single edge that samples it.

The bench drives every input on the falling clock edge and samples at later falling edges. Timing checks sample exactly one edge before and at the edge where each result is due. Table-driven checks wait four full edges, by which time every path has settled.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int SEL_W   = 4;
    localparam int PIN_CNT = 1 << SEL_W;
    localparam int CH_BITS = 8;

    typedef enum logic [1:0] {
        DET_LEVEL = 2'd0,
        DET_EDGE  = 2'd1,
        DET_BOTH  = 2'd2,
        DET_RSVD  = 2'd3
    } det_mode_e;

    // Packed MSB first so that it overlays one control byte: en, mode, pol, sel.
    typedef struct packed {
        logic             en;
        det_mode_e        mode;
        logic             pol;
        logic [SEL_W-1:0] sel;
    } chan_cfg_t;

    function automatic logic det_active(chan_cfg_t c);
        return c.en && (c.mode != DET_RSVD);
    endfunction

    function automatic logic is_level(chan_cfg_t c);
        return c.mode == DET_LEVEL;
    endfunction

    function automatic logic edge_hit(chan_cfg_t c, logic cur, logic prv);
        logic rise;
        logic fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        case (c.mode)
            DET_EDGE: return c.pol ? rise : fall;
            DET_BOTH: return rise | fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/eirq_cfg_reg.sv
module eirq_cfg_reg
    import eirq_pkg::*;
#(
    parameter int CFG_W  = 32,
    parameter int NUM_CH = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [CFG_W-1:0]             wdata,
    output logic [CFG_W-1:0]             word_q,
    output chan_cfg_t [NUM_CH-1:0]       cfg_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (we) begin
            word_q <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slice
        assign cfg_o[g] = chan_cfg_t'(word_q[g*CH_BITS +: CH_BITS]);
    end

endmodule

// File: rtl/eirq_pin_sync.sv
module eirq_pin_sync
    import eirq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PIN_CNT-1:0] pins,
    input  logic [SEL_W-1:0]   sel,
    output logic               cur,
    output logic               prv,
    output logic               settling
);

    localparam int CNT_W = $clog2(STAGES + 1);

    logic [STAGES-1:0] shf;
    logic [SEL_W-1:0]  sel_q;
    logic [CNT_W-1:0]  cnt;
    logic              sel_moved;

    assign sel_moved = (sel_q != sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            shf <= '0;
            prv <= 1'b0;
        end else begin
            shf <= {shf[STAGES-2:0], pins[sel]};
            prv <= shf[STAGES-1];
        end
    end

    // After a select change the stale samples drain for STAGES edges;
    // the history keeps tracking so no edge is seen once they are gone.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            cnt   <= '0;
        end else begin
            sel_q <= sel;
            if (sel_moved) begin
                cnt <= CNT_W'(STAGES);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign cur      = shf[STAGES-1];
    assign settling = sel_moved || (cnt != '0);

endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
    import eirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  logic      cur,
    input  logic      prv,
    input  logic      settling,
    input  logic      clr,
    output logic      irq
);

    logic pending;
    logic hit;

    assign hit = !settling && edge_hit(cfg, cur, prv);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (!det_active(cfg) || is_level(cfg)) begin
            pending <= 1'b0;
        end else if (hit) begin
            pending <= 1'b1;
        end else if (clr) begin
            pending <= 1'b0;
        end
    end

    always_comb begin
        if (!det_active(cfg)) begin
            irq = 1'b0;
        end else if (is_level(cfg)) begin
            irq = (cur == cfg.pol);
        end else begin
            irq = pending;
        end
    end

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import eirq_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CFG_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [CFG_W-1:0]          cfg_wdata,
    input  logic [NUM_CH*PIN_CNT-1:0] pins_in,
    input  logic [NUM_CH-1:0]         irq_clr,
    output logic [NUM_CH-1:0]         irq_req
);

    logic [CFG_W-1:0]        ctl_word;
    chan_cfg_t [NUM_CH-1:0]  ch_cfg;

    eirq_cfg_reg #(
        .CFG_W  (CFG_W),
        .NUM_CH (NUM_CH)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .word_q (ctl_word),
        .cfg_o  (ch_cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic cur;
        logic prv;
        logic settling;

        eirq_pin_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk      (clk),
            .rst      (rst),
            .pins     (pins_in[c*PIN_CNT +: PIN_CNT]),
            .sel      (ch_cfg[c].sel),
            .cur      (cur),
            .prv      (prv),
            .settling (settling)
        );

        eirq_detect u_det (
            .clk      (clk),
            .rst      (rst),
            .cfg      (ch_cfg[c]),
            .cur      (cur),
            .prv      (prv),
            .settling (settling),
            .clr      (irq_clr[c]),
            .irq      (irq_req[c])
        );
    end

endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
    parameter int NUM_CH = 2,
    parameter int CFG_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [CFG_W-1:0]  ctl_word,
    input logic [NUM_CH-1:0] irq_clr,
    input logic [NUM_CH-1:0] irq_req
);

    logic rst_d = 1'b0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            a_r1_reset_clean: assert (ctl_word == '0 && irq_req == '0)
                else $error("R1: state not clean after reset");
        end
    end

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
        logic [7:0] b;
        logic [7:0] nb;
        assign b  = ctl_word[gi*8 +: 8];
        assign nb = cfg_wdata[gi*8 +: 8];

        a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
            !b[7] |-> !irq_req[gi]);

        a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
            (b[6:5] == 2'd3) |-> !irq_req[gi]);

        a_r6_pending_holds: assert property (@(posedge clk) disable iff (rst)
            (b[7] && (b[6:5] == 2'd1 || b[6:5] == 2'd2) && irq_req[gi]
             && !irq_clr[gi] && !cfg_we) |=> irq_req[gi]);

        a_r9_select_no_edge: assert property (@(posedge clk) disable iff (rst)
            (b[7] && b[6:5] == 2'd1 && !irq_req[gi] && cfg_we
             && nb[7:5] == b[7:5] && nb[3:0] != b[3:0]) |=> !irq_req[gi]);
    end

endmodule

bind ext_irq_detect eirq_chk #(
    .NUM_CH (NUM_CH),
    .CFG_W  (CFG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .ctl_word  (ctl_word),
    .irq_clr   (irq_clr),
    .irq_req   (irq_req)
);

// File: tb/tb_ext_irq_detect.sv
module tb_ext_irq_detect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] pins_in = '0;
    logic [1:0]  irq_clr = '0;
    logic [1:0]  irq_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ext_irq_detect dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .pins_in   (pins_in),
        .irq_clr   (irq_clr),
        .irq_req   (irq_req)
    );

    typedef struct packed {
        logic [31:0] cfg;
        logic [15:0] p0;
        logic [15:0] p1;
        logic [1:0]  clr;
        logic [1:0]  exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0083, 16'h0000, 16'h0000, 2'b00, 2'b01},
        '{32'h0000_0083, 16'h0008, 16'h0000, 2'b00, 2'b00},
        '{32'h0000_0093, 16'h0008, 16'h0000, 2'b00, 2'b01},
        '{32'h0000_00B5, 16'h0008, 16'h0000, 2'b00, 2'b00},
        '{32'h0000_00B5, 16'h0020, 16'h0000, 2'b00, 2'b01},
        '{32'h0000_00B5, 16'h0000, 16'h0000, 2'b00, 2'b01},
        '{32'h0000_00B5, 16'h0000, 16'h0000, 2'b01, 2'b00},
        '{32'h0000_00B5, 16'h0010, 16'h0000, 2'b00, 2'b00},
        '{32'h0000_AFC5, 16'h0010, 16'hFFFF, 2'b00, 2'b00},
        '{32'h0000_AFC5, 16'h0030, 16'hFFFF, 2'b00, 2'b01},
        '{32'h0000_AFC5, 16'h0010, 16'hFFFF, 2'b01, 2'b01},
        '{32'h0000_AFC5, 16'h0010, 16'hFFFF, 2'b01, 2'b00},
        '{32'h0000_AFC5, 16'h0010, 16'h7FFF, 2'b00, 2'b10},
        '{32'h0000_AFC5, 16'h0010, 16'h7FFF, 2'b01, 2'b10},
        '{32'h0000_2FC5, 16'h0010, 16'h7FFF, 2'b00, 2'b00},
        '{32'h0000_00E5, 16'h0030, 16'h7FFF, 2'b00, 2'b00},
        '{32'hFFFF_0093, 16'h0008, 16'h0000, 2'b00, 2'b01}
    };

    function automatic string vtag(int i);
        case (i)
            0, 1, 2:  return "R3";
            3, 8:     return "R9";
            4, 12:    return "R4";
            5, 6, 11: return "R6";
            7:        return "R8";
            9, 10:    return "R5";
            13:       return "R10";
            14, 15:   return "R7";
            default:  return "R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq_req=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = 2'b00;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_edges(3);
        check("R1", irq_req, 2'b00);
        @(negedge clk);
        rst = 1'b0;
        wait_edges(2);
        check("R1", irq_req, 2'b00);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_we    = 1'b1;
            cfg_wdata = VEC[i].cfg;
            pins_in   = {VEC[i].p1, VEC[i].p0};
            irq_clr   = VEC[i].clr;
            @(negedge clk);
            cfg_we  = 1'b0;
            irq_clr = 2'b00;
            wait_edges(4);
            check(vtag(i), irq_req, VEC[i].exp);
        end

        // R3: level timing, polarity 1, pin 0
        write_cfg(32'h0000_0090);
        pins_in = '0;
        wait_edges(4);
        check("R3", irq_req, 2'b00);
        pins_in[0] = 1'b1;
        wait_edges(1);
        check("R3", irq_req, 2'b00);
        wait_edges(1);
        check("R3", irq_req, 2'b01);
        pins_in[0] = 1'b0;
        wait_edges(1);
        check("R3", irq_req, 2'b01);
        wait_edges(1);
        check("R3", irq_req, 2'b00);

        // R4: rising edge latch timing
        write_cfg(32'h0000_00B0);
        wait_edges(4);
        pins_in[0] = 1'b1;
        wait_edges(2);
        check("R4", irq_req, 2'b00);
        wait_edges(1);
        check("R4", irq_req, 2'b01);
        pulse_clr(2'b01);
        check("R6", irq_req, 2'b00);
        // R4: falling edge ignored with polarity 1
        pins_in[0] = 1'b0;
        wait_edges(5);
        check("R4", irq_req, 2'b00);

        // R6: new edge and clear at the same edge
        pins_in[0] = 1'b1;
        wait_edges(2);
        irq_clr = 2'b01;
        wait_edges(1);
        irq_clr = 2'b00;
        check("R6", irq_req, 2'b01);
        pulse_clr(2'b01);
        check("R6", irq_req, 2'b00);

        // R9: select change between pins at different levels
        pins_in[15:0] = 16'h0002;
        wait_edges(5);
        pulse_clr(2'b01);
        check("R9", irq_req, 2'b00);
        write_cfg(32'h0000_00B1);
        wait_edges(6);
        check("R9", irq_req, 2'b00);
        write_cfg(32'h0000_00C0);
        wait_edges(6);
        check("R9", irq_req, 2'b00);
        pins_in[0] = 1'b1;
        wait_edges(3);
        check("R5", irq_req, 2'b01);

        // R1: reset clears a live configuration
        write_cfg(32'h0000_0083);
        pins_in = '0;
        wait_edges(4);
        check("R1", irq_req, 2'b01);
        @(negedge clk);
        rst = 1'b1;
        wait_edges(2);
        rst = 1'b0;
        wait_edges(3);
        check("R1", irq_req, 2'b00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule